// File: doc/BRIEF.md
# Asynchronous Serial Transmitter/Receiver with Register Interface

This block is a full-duplex asynchronous serial port that sits behind a four-location byte-wide register interface. Software sets a character size of 5 to 9 data bits, turns the transmit and receive directions on and off on their own, and can ask for an interrupt whenever the transmit holding buffer can take a new character. A write to the data location commits a character for transmission. A read of the data location pops the oldest received character from a two-entry receive queue.

Frames have one low start bit, the data bits with the least significant bit first, and one high stop bit. Each bit lasts 16 ticks of an internal oversampling clock. That tick comes every `baud_div + 1` core clock cycles. The receiver takes three samples around the middle of each bit and keeps the majority value. The serial pins are claimed only while their direction is on. Turning the transmitter off does not cut a character short: the pin stays claimed until the shifter and the buffer are both empty. Turning the receiver off discards the queue and the error flags. The mode field is decoded only so that a non-asynchronous setting can be flagged.

Top module: `ser_port_core`

Register map (`bus_addr`): 0 = data, 1 = status (read only), 2 = control B, 3 = control C. Status: bit0 = received character available, bit1 = transmit buffer empty, bit2 = frame error of the oldest received character, bit3 = overrun. Control B: bit0 = receiver on, bit1 = transmitter on, bit2 = buffer-empty interrupt enable, bit3 = high size bit, bit4 = transmit ninth bit, bit5 = received ninth bit (read only). Control C: bits 1:0 = low size bits, bits 3:2 = mode.

## Requirements
- R1: After reset, control B reads 0x00, control C reads 0x03 (mode 00, low size bits 11), status reads 0x02, `txd_oe`=0, `txd_out`=1, `rxd_own`=0, `irq_dre`=0 and `mode_err`=0.
- R2: The size code {control B bit3, control C bits 1:0} selects the data bit count: 000→5, 001→6, 010→7, 011→8, 111→9. Every other code selects 8.
- R3: A transmitted frame is a low start bit, then the data bits LSB first, then a high stop bit. Each bit lasts 16·(`baud_div`+1) clock cycles. `txd_out` is high whenever no frame is being shifted.
- R4: In 9-bit mode the ninth transmitted bit is the value of control B bit4 at the moment the data byte is written. A later change of bit4 does not alter a character that is already committed.
- R5: A data write is accepted only when the transmitter is on and status bit1 is 1. An accepted write clears bit1. Any other data write is ignored. Bit1 sets again when the buffer moves into the shifter.
- R6: When control B bit1 is cleared, `txd_oe` stays 1 until the shifter and the buffer hold no data. It then drops to 0, with `txd_out` at 1.
- R7: `irq_dre` is 1 exactly when control B bit2, the input `gie` and status bit1 are all 1.
- R8: `rxd_own` follows control B bit0. A received frame sets status bit0. Control B bit5 shows the ninth bit of the oldest character, and a read of the data location returns its low byte and removes it.
- R9: The receive queue holds two characters. A character that completes while the queue is full is discarded and sets status bit3. Bit3 clears on a data read or when the receiver is turned off.
- R10: A stop bit sampled low sets status bit2 for that character, and the character is still queued.
- R11: Clearing control B bit0 empties the queue and clears status bits 2 and 3. Frames on `rxd_in` while the receiver is off leave no character behind.
- R12: Control C bits 3:2 select the mode (00 asynchronous, 01 synchronous, 10 reserved, 11 SPI master). `mode_err` is 1 whenever the field is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global interrupt enable |
| baud_div | input | DIV_W | Oversampling tick divider (tick every baud_div+1 cycles) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data location) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| txd_out | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Transmitter owns the TXD pin |
| rxd_in | input | 1 | Serial receive line |
| rxd_own | output | 1 | Receiver owns the RXD pin |
| irq_dre | output | 1 | Transmit-buffer-empty interrupt |
| mode_err | output | 1 | Mode field selects a non-asynchronous mode |

## Verification
The bench turns the transmitter off while one character is in the shifter and a second waits in the buffer. A design that drops the pin at once would clip both frames, and one that releases after only the shifter empties would lose the second. It changes the transmit ninth bit right after committing a 9-bit character, and it sends three characters to a full queue. A design that latches the ninth bit late sends the wrong bit. A wrongly sized queue loses the first character or keeps the third. It also sends a frame with a low stop bit and then turns the receiver off, which exposes flags that outlive the flush, and it uses a reserved size code, which a decoder that does not fall back to 8 bits would get wrong.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_CTLB = 2'd2;
   localparam logic [1:0] ADDR_CTLC = 2'd3;

   localparam int MAX_DBITS = 9;
   localparam int FRAME_W   = MAX_DBITS + 2;

   typedef enum logic [1:0] {
      MODE_ASYNC = 2'b00,
      MODE_SYNC  = 2'b01,
      MODE_RSVD  = 2'b10,
      MODE_SPIM  = 2'b11
   } mode_t;

   typedef struct packed {
      logic                 ferr;
      logic [MAX_DBITS-1:0] data;
   } rx_entry_t;

   function automatic logic [3:0] size_bits(input logic [2:0] code);
      case (code)
         3'b000:  return 4'd5;
         3'b001:  return 4'd6;
         3'b010:  return 4'd7;
         3'b011:  return 4'd8;
         3'b111:  return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

   function automatic logic [FRAME_W-1:0] frame_of(input logic [MAX_DBITS-1:0] d,
                                                   input logic [3:0] n);
      logic [FRAME_W-1:0] f;
      f    = '1;
      f[0] = 1'b0;
      for (int i = 0; i < MAX_DBITS; i++) begin
         if (i < int'(n)) f[i+1] = d[i];
      end
      return f;
   endfunction

endpackage

// File: rtl/ser_baud_tick.sv
module ser_baud_tick #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= div) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/ser_tx.sv
module ser_tx
   import ser_port_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 en_req,
   input  logic                 wr_stb,
   input  logic [MAX_DBITS-1:0] wr_data,
   input  logic [3:0]           nbits,
   output logic                 buf_empty,
   output logic                 busy,
   output logic                 drive,
   output logic                 txd
);
   localparam int OVS_W = $clog2(OVS);

   logic                 buf_v;
   logic [MAX_DBITS-1:0] buf_d;
   logic [3:0]           buf_n;
   logic [FRAME_W-1:0]   frame;
   logic [3:0]           bits_left;
   logic [OVS_W-1:0]     sub;
   logic                 load;

   assign load      = !busy && buf_v;
   assign buf_empty = !buf_v;
   assign txd       = (drive && busy) ? frame[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_v     <= 1'b0;
         buf_d     <= '0;
         buf_n     <= 4'd8;
         busy      <= 1'b0;
         frame     <= '1;
         bits_left <= '0;
         sub       <= '0;
         drive     <= 1'b0;
      end else begin
         drive <= en_req || (drive && (busy || buf_v));
         if (wr_stb && !buf_v) begin
            buf_v <= 1'b1;
            buf_d <= wr_data;
            buf_n <= nbits;
         end
         if (load) begin
            busy      <= 1'b1;
            frame     <= frame_of(buf_d, buf_n);
            bits_left <= buf_n + 4'd2;
            sub       <= '0;
            buf_v     <= 1'b0;
         end else if (busy && tick) begin
            if (sub == OVS_W'(OVS - 1)) begin
               sub       <= '0;
               frame     <= {1'b1, frame[FRAME_W-1:1]};
               bits_left <= bits_left - 4'd1;
               if (bits_left == 4'd1) busy <= 1'b0;
            end else begin
               sub <= sub + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ser_rx.sv
module ser_rx
   import ser_port_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      en,
   input  logic      rxd,
   input  logic [3:0] nbits,
   output logic      push,
   output rx_entry_t push_entry
);
   localparam int OVS_W = $clog2(OVS);
   localparam logic [OVS_W-1:0] SP0 = OVS_W'(OVS / 2 - 1);
   localparam logic [OVS_W-1:0] SP1 = OVS_W'(OVS / 2);
   localparam logic [OVS_W-1:0] SP2 = OVS_W'(OVS / 2 + 1);
   localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

   logic [1:0]           sync;
   logic                 rx_s;
   logic                 active;
   logic [OVS_W-1:0]     cnt;
   logic [3:0]           idx;
   logic [3:0]           n_q;
   logic [1:0]           ones;
   logic                 vote;
   logic [MAX_DBITS-1:0] sh;

   assign rx_s = sync[1];
   assign vote = ones[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync       <= 2'b11;
         active     <= 1'b0;
         cnt        <= '0;
         idx        <= '0;
         n_q        <= 4'd8;
         ones       <= '0;
         sh         <= '0;
         push       <= 1'b0;
         push_entry <= '0;
      end else begin
         push <= 1'b0;
         sync <= {sync[0], rxd};
         if (!en) begin
            active <= 1'b0;
         end else if (tick) begin
            if (!active) begin
               if (!rx_s) begin
                  active <= 1'b1;
                  cnt    <= '0;
                  idx    <= '0;
                  ones   <= '0;
                  sh     <= '0;
                  n_q    <= nbits;
               end
            end else begin
               if (cnt == SP0 || cnt == SP1 || cnt == SP2)
                  ones <= ones + {1'b0, rx_s};
               if (cnt == LAST) begin
                  cnt  <= '0;
                  ones <= '0;
                  if (idx == 4'd0) begin
                     if (vote) active <= 1'b0;
                     else      idx    <= 4'd1;
                  end else if (idx <= n_q) begin
                     sh[idx - 4'd1] <= vote;
                     idx            <= idx + 4'd1;
                  end else begin
                     push            <= 1'b1;
                     push_entry.ferr <= !vote;
                     push_entry.data <= sh;
                     active          <= 1'b0;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ser_rx_fifo.sv
module ser_rx_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("ser_rx_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic         v;
         logic [W-1:0] d;
         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               v <= 1'b0;
               d <= '0;
            end else begin
               if (pop && v) v <= 1'b0;
               if (push && !v) begin
                  v <= 1'b1;
                  d <= din;
               end
            end
         end
         assign dout  = v ? d : '0;
         assign empty = !v;
         assign full  = v;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
            $error("ser_rx_fifo: DEPTH must be a power of two");
         end
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] rd_p, wr_p;
         logic [CNT_W-1:0] cnt;
         logic             do_push, do_pop;

         assign empty   = (cnt == '0);
         assign full    = (cnt == CNT_W'(DEPTH));
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;
         assign dout    = empty ? '0 : mem[rd_p];

         always_ff @(posedge clk) begin
            if (do_push && !flush) mem[wr_p] <= din;
         end

         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               rd_p <= '0;
               wr_p <= '0;
               cnt  <= '0;
            end else begin
               if (do_push) wr_p <= wr_p + 1'b1;
               if (do_pop)  rd_p <= rd_p + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   cnt <= cnt + 1'b1;
                  2'b01:   cnt <= cnt - 1'b1;
                  default: cnt <= cnt;
               endcase
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ser_port_core.sv
module ser_port_core
   import ser_port_pkg::*;
#(
   parameter int DIV_W    = 12,
   parameter int OVS      = 16,
   parameter int RX_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gie,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic             txd_out,
   output logic             txd_oe,
   input  logic             rxd_in,
   output logic             rxd_own,
   output logic             irq_dre,
   output logic             mode_err
);
   localparam int ENTRY_W = $bits(rx_entry_t);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("ser_port_core: DIV_W must be at least 1");
      end
      if (OVS < 8) begin : g_bad_ovs
         $error("ser_port_core: OVS must be at least 8 for three mid-bit samples");
      end
   endgenerate

   // control state
   logic       ctl_rx_en, ctl_tx_en, ctl_dre_ie, ctl_size_hi, ctl_tx_b9;
   logic [1:0] ctl_size_lo;
   mode_t      ctl_mode;
   logic [3:0] nbits;

   // datapath links
   logic       tick;
   logic       wr_data_stb, rd_pop;
   logic       tx_buf_empty, tx_busy;
   logic       rx_push;
   rx_entry_t  rx_new, rx_head;
   logic       fifo_empty, fifo_full;
   logic       ovr_flag;

   assign nbits       = size_bits({ctl_size_hi, ctl_size_lo});
   assign wr_data_stb = bus_wr && (bus_addr == ADDR_DATA) && ctl_tx_en;
   assign rd_pop      = bus_rd && (bus_addr == ADDR_DATA) && !fifo_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_rx_en   <= 1'b0;
         ctl_tx_en   <= 1'b0;
         ctl_dre_ie  <= 1'b0;
         ctl_size_hi <= 1'b0;
         ctl_tx_b9   <= 1'b0;
         ctl_size_lo <= 2'b11;
         ctl_mode    <= MODE_ASYNC;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_CTLB) begin
            ctl_rx_en   <= bus_wdata[0];
            ctl_tx_en   <= bus_wdata[1];
            ctl_dre_ie  <= bus_wdata[2];
            ctl_size_hi <= bus_wdata[3];
            ctl_tx_b9   <= bus_wdata[4];
         end else if (bus_addr == ADDR_CTLC) begin
            ctl_size_lo <= bus_wdata[1:0];
            ctl_mode    <= mode_t'(bus_wdata[3:2]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   ovr_flag <= 1'b0;
      else if (!ctl_rx_en || rd_pop) ovr_flag <= 1'b0;
      else if (rx_push && fifo_full) ovr_flag <= 1'b1;
   end

   ser_baud_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (baud_div),
      .tick (tick)
   );

   ser_tx #(.OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .en_req   (ctl_tx_en),
      .wr_stb   (wr_data_stb),
      .wr_data  ({ctl_tx_b9, bus_wdata}),
      .nbits    (nbits),
      .buf_empty(tx_buf_empty),
      .busy     (tx_busy),
      .drive    (txd_oe),
      .txd      (txd_out)
   );

   ser_rx #(.OVS(OVS)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .en        (ctl_rx_en),
      .rxd       (rxd_in),
      .nbits     (nbits),
      .push      (rx_push),
      .push_entry(rx_new)
   );

   ser_rx_fifo #(.DEPTH(RX_DEPTH), .W(ENTRY_W)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(!ctl_rx_en),
      .push (rx_push),
      .din  (rx_new),
      .pop  (rd_pop),
      .dout (rx_head),
      .empty(fifo_empty),
      .full (fifo_full)
   );

   assign rxd_own  = ctl_rx_en;
   assign irq_dre  = ctl_dre_ie && gie && tx_buf_empty;
   assign mode_err = (ctl_mode != MODE_ASYNC);

   always_comb begin
      case (bus_addr)
         ADDR_DATA: bus_rdata = rx_head.data[7:0];
         ADDR_STAT: bus_rdata = {4'b0, ovr_flag, rx_head.ferr, tx_buf_empty, !fifo_empty};
         ADDR_CTLB: bus_rdata = {2'b0, rx_head.data[8], ctl_tx_b9, ctl_size_hi,
                                 ctl_dre_ie, ctl_tx_en, ctl_rx_en};
         default:   bus_rdata = {4'b0, ctl_mode, ctl_size_lo};
      endcase
   end
endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_tx_en,
   input logic ctl_rx_en,
   input logic tx_busy,
   input logic tx_buf_empty,
   input logic txd_oe,
   input logic txd_out,
   input logic wr_data_stb,
   input logic irq_dre,
   input logic fifo_empty,
   input logic fifo_full,
   input logic ovr_flag,
   input logic rx_push
);
   // R3: line idles high whenever nothing is being shifted
   a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd_out);

   // R5: an accepted data write removes the buffer-empty interrupt
   a_r5_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_stb && tx_buf_empty) |=> !irq_dre);

   // R6: pin stays claimed while data remains
   a_r6_hold_while_data: assert property (@(posedge clk) disable iff (!rst_n)
      (txd_oe && (tx_busy || !tx_buf_empty)) |=> txd_oe);

   // R6: pin released once disabled and drained
   a_r6_release_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_tx_en && !tx_busy && tx_buf_empty) |=> !txd_oe);

   // R9: overrun rises only from a completed character meeting a full queue
   a_r9_overrun_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $past(fifo_full && rx_push));

   // R11: receiver off leaves an empty queue and no overrun
   a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rx_en |=> (fifo_empty && !ovr_flag));
endmodule

bind ser_port_core ser_port_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_tx_en   (ctl_tx_en),
   .ctl_rx_en   (ctl_rx_en),
   .tx_busy     (tx_busy),
   .tx_buf_empty(tx_buf_empty),
   .txd_oe      (txd_oe),
   .txd_out     (txd_out),
   .wr_data_stb (wr_data_stb),
   .irq_dre     (irq_dre),
   .fifo_empty  (fifo_empty),
   .fifo_full   (fifo_full),
   .ovr_flag    (ovr_flag),
   .rx_push     (rx_push)
);

// File: tb/ser_port_core_tb_top.sv
module ser_port_core_tb_top;
   localparam int DIV_W = 12;
   localparam int DIV   = 3;
   localparam int BP    = 16 * (DIV + 1);

   // vector: {size code[2:0], data[8:0]}
   localparam int NVEC = 6;
   localparam logic [11:0] VEC [NVEC] = '{
      {3'b000, 9'h015}, {3'b001, 9'h02A}, {3'b010, 9'h055},
      {3'b011, 9'h0A5}, {3'b111, 9'h1C3}, {3'b101, 9'h13C}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             gie = 1'b0;
   logic [DIV_W-1:0] baud_div = DIV_W'(DIV);
   logic             bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]       bus_addr = 2'd0;
   logic [7:0]       bus_wdata = 8'h00;
   logic [7:0]       bus_rdata;
   logic             txd_out, txd_oe, rxd_own, irq_dre, mode_err;
   logic             rxd_in = 1'b1;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ser_port_core #(.DIV_W(DIV_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .gie(gie), .baud_div(baud_div),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .txd_out(txd_out), .txd_oe(txd_oe), .rxd_in(rxd_in),
      .rxd_own(rxd_own), .irq_dre(irq_dre), .mode_err(mode_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int dbits(input logic [2:0] code);
      case (code)
         3'b000: return 5;
         3'b001: return 6;
         3'b010: return 7;
         3'b011: return 8;
         3'b111: return 9;
         default: return 8;
      endcase
   endfunction

   function automatic logic [7:0] ctlb(input logic tb9, input logic shi, input logic ie,
                                       input logic te, input logic re);
      return {3'b000, tb9, shi, ie, te, re};
   endfunction

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tx_capture(input int n, output logic [8:0] d, output logic st, output logic sp);
      d = '0;
      while (txd_out !== 1'b0) @(negedge clk);
      repeat (BP / 2) @(negedge clk);
      st = txd_out;
      for (int i = 0; i < n; i++) begin
         repeat (BP) @(negedge clk);
         d[i] = txd_out;
      end
      repeat (BP) @(negedge clk);
      sp = txd_out;
   endtask

   task automatic rx_send(input int n, input logic [8:0] d, input logic stop);
      @(negedge clk);
      rxd_in = 1'b0;
      repeat (BP) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rxd_in = d[i];
         repeat (BP) @(negedge clk);
      end
      rxd_in = stop;
      repeat (BP) @(negedge clk);
      rxd_in = 1'b1;
      repeat (2 * BP) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic [8:0] cap;
      logic       st, sp;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      bus_read(2'd2, r); check("R1 ctlB", r, 8'h00);
      bus_read(2'd3, r); check("R1 ctlC", r, 8'h03);
      bus_read(2'd1, r); check("R1 status", r, 8'h02);
      check("R1 txd_oe", txd_oe, 1'b0);
      check("R1 txd_out", txd_out, 1'b1);
      check("R1 rxd_own", rxd_own, 1'b0);
      check("R1 irq", irq_dre, 1'b0);
      check("R1 mode_err", mode_err, 1'b0);

      // R5: data write with transmitter off is ignored
      bus_write(2'd0, 8'h5A);
      repeat (4) @(negedge clk);
      bus_read(2'd1, r); check("R5 ignored write keeps empty", r[1], 1'b1);
      check("R5 no drive", txd_oe, 1'b0);

      // vector table: R2 size, R3 tx frame, R8 rx path
      for (int v = 0; v < NVEC; v++) begin
         logic [2:0] code;
         logic [8:0] d, mask;
         int         n;
         code = VEC[v][11:9];
         d    = VEC[v][8:0];
         n    = dbits(code);
         mask = 9'((1 << n) - 1);
         bus_write(2'd3, {6'b0, code[1:0]});
         bus_write(2'd2, ctlb(d[8], code[2], 1'b0, 1'b1, 1'b1));
         bus_write(2'd0, d[7:0]);
         if (n == 9) bus_write(2'd2, ctlb(~d[8], code[2], 1'b0, 1'b1, 1'b1)); // R4
         tx_capture(n, cap, st, sp);
         check("R3 start bit", st, 1'b0);
         check((n == 9) ? "R4 R2 tx data" : "R2 R3 tx data", cap, d & mask);
         check("R3 stop bit", sp, 1'b1);
         if (n == 9) bus_write(2'd2, ctlb(d[8], code[2], 1'b0, 1'b1, 1'b1));
         rx_send(n, d, 1'b1);
         bus_read(2'd1, r); check("R8 rx available", r[0], 1'b1);
         bus_read(2'd2, r); check("R8 rx ninth bit", r[5], (n == 9) ? d[8] : 1'b0);
         bus_read(2'd0, r); check("R2 R8 rx data", r, 8'(d & mask));
         bus_read(2'd1, r); check("R8 popped", r[0], 1'b0);
      end

      // R7: interrupt gating
      bus_write(2'd3, 8'h03);
      bus_write(2'd2, ctlb(1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
      gie = 1'b0; @(negedge clk);
      check("R7 gie low", irq_dre, 1'b0);
      gie = 1'b1; @(negedge clk);
      check("R7 all set", irq_dre, 1'b1);
      bus_write(2'd2, ctlb(1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
      check("R7 enable low", irq_dre, 1'b0);

      // R5/R6: buffer full write ignored, deferred disable
      bus_write(2'd0, 8'hC3);
      repeat (3) @(negedge clk);
      bus_write(2'd0, 8'h5A);
      bus_read(2'd1, r); check("R5 buffer full", r[1], 1'b0);
      bus_write(2'd0, 8'hFF);
      bus_write(2'd2, ctlb(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      check("R6 still driving", txd_oe, 1'b1);
      tx_capture(8, cap, st, sp);
      check("R6 first frame", cap, 9'h0C3);
      tx_capture(8, cap, st, sp);
      check("R5 R6 second frame not overwritten", cap, 9'h05A);
      check("R6 stop of second", sp, 1'b1);
      repeat (2 * BP) @(negedge clk);
      check("R6 released", txd_oe, 1'b0);
      check("R6 line high", txd_out, 1'b1);

      // R9: overrun
      rx_send(8, 9'h011, 1'b1);
      rx_send(8, 9'h022, 1'b1);
      rx_send(8, 9'h033, 1'b1);
      bus_read(2'd1, r); check("R9 overrun set", r[3], 1'b1);
      bus_read(2'd0, r); check("R9 first kept", r, 8'h11);
      bus_read(2'd1, r); check("R9 overrun cleared by read", r[3], 1'b0);
      bus_read(2'd0, r); check("R9 second kept", r, 8'h22);
      bus_read(2'd1, r); check("R9 third discarded", r[0], 1'b0);

      // R10: frame error
      rx_send(8, 9'h077, 1'b0);
      bus_read(2'd1, r); check("R10 frame error", r[2], 1'b1);
      bus_read(2'd0, r); check("R10 data still queued", r, 8'h77);

      // R11: flush on disable
      rx_send(8, 9'h044, 1'b0);
      bus_write(2'd2, ctlb(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      check("R8 rxd_own off", rxd_own, 1'b0);
      bus_read(2'd1, r); check("R11 flushed", r & 8'h0D, 8'h00);
      rx_send(8, 9'h099, 1'b1);
      bus_write(2'd2, ctlb(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      check("R8 rxd_own on", rxd_own, 1'b1);
      repeat (BP) @(negedge clk);
      bus_read(2'd1, r); check("R11 input ignored while off", r[0], 1'b0);

      // R12: mode flag
      bus_write(2'd3, 8'h07);
      check("R12 sync flagged", mode_err, 1'b1);
      bus_read(2'd3, r); check("R12 readback", r, 8'h07);
      bus_write(2'd3, 8'h0F);
      check("R12 spi flagged", mode_err, 1'b1);
      bus_write(2'd3, 8'h03);
      check("R12 async clear", mode_err, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule